// File: doc/BRIEF.md
# Peak Level Monitor and Level-Code Encoder

The block watches a stream of 20-bit two's-complement audio samples, each tagged as left or right. It keeps the largest magnitude seen on each channel in an active register, together with a sticky overrange flag and the largest overrange excess. A falling edge on the asynchronous update input moves each channel's active contents into a held register and restarts the active register. The input is synchronized before the edge is detected.

Each held peak is turned into an 8-bit level code. The code takes one of two forms: a decibel code with 1 dB resolution, or a nonuniform thermometer bar. The form is latched while reset is asserted. A single overflow pin carries the held overrange flag of whichever channel the frame clock currently selects. A serializer downstream places these flags in its outgoing frames.

Top module: `peak_level_monitor`

## Requirements
- R1: `upd_n` passes through a two-flop synchronizer. If `upd_n` is sampled high at one rising edge and low at the next edge (edge n), the held registers load the active contents at edge n+2. At that same edge the active register restarts. It holds the sample of its own channel presented at that edge, or zero if there is none.
- R2: Between updates, the active magnitude of a channel is the largest absolute value of its valid samples. A channel's samples have `smp_valid`=1 and `smp_right` equal to 1 for right, 0 for left. The most negative code 0x80000 counts as 0x7FFFF.
- R3: The thresholds are T0=524287 and T(k+1)=floor(T(k)*58409/65536), for k up to 60. The attenuation `a` is the count of k in 0..59 with peak < T(k), so peak = T(k) gives k. The peak is idle when it is below T60.
- R4: In decibel form, bit 7 is the held overrange flag. Bit 6 is 1 when the peak is idle and there is no overrange. Bits 5..0 hold `a` (0 to 60) when there is no overrange.
- R5: With overrange held, bits 5..0 carry the largest `smp_excess` seen with `smp_over`=1 since the last update, in dB above full scale (0 to 3).
- R6: In bar form the code is 0xFF on overrange and 0x00 when idle. Otherwise it is 0x7F for a<=3, 0x3F for a<=6, 0x1F for a<=10, 0x0F for a<=20, 0x07 for a<=30, 0x03 for a<=40, and 0x01 otherwise.
- R7: `ovfl` shows the held overrange flag of the left channel while `lr_right`=0 and of the right channel while `lr_right`=1.
- R8: `bar_mode` is captured on every clock edge with `rst_n` low (1 = bar form) and is ignored otherwise.
- R9: Reset is synchronous and active low. After reset the active and held registers are zero, so the decibel code is 0x7C, the bar code is 0x00 and `ovfl` is 0.
- R10: The two channels are independent. Samples for one channel never change the other channel's registers or code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | A sample is presented this cycle |
| smp_right | input | 1 | Channel tag: 1 right, 0 left |
| smp_data | input | 20 | Two's-complement sample |
| smp_over | input | 1 | Sample was clipped from a wider value |
| smp_excess | input | 2 | Clipped excess in dB above full scale |
| upd_n | input | 1 | Asynchronous update request, active on falling edge |
| lr_right | input | 1 | Frame clock phase: 1 right half, 0 left half |
| bar_mode | input | 1 | Code form selection, captured in reset |
| lvl_left | output | 8 | Left channel level code |
| lvl_right | output | 8 | Right channel level code |
| ovfl | output | 1 | Overrange flag of the selected channel |

## Verification
The assertions assume that reset is held for at least two clock cycles and that `bar_mode` does not change during that reset window. The bench changes `bar_mode` only before it asserts reset, or after reset is released to show that the input is ignored. The `smp_excess` field is assumed to matter only with `smp_over` set. Random stimulus also drives it when `smp_over` is low, and the model and the assertions both disregard it there. The update input toggles with random gaps that are shorter than the synchronizer depth, so edges that arrive back to back are exercised as well as isolated ones.

// File: rtl/peak_level_monitor.sv
module peak_level_monitor #(
  parameter int W     = 20,
  parameter int STEPS = 60,
  parameter int RATIO = 58409
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_valid,
  input  logic         smp_right,
  input  logic [W-1:0] smp_data,
  input  logic         smp_over,
  input  logic [1:0]   smp_excess,
  input  logic         upd_n,
  input  logic         lr_right,
  input  logic         bar_mode,
  output logic [7:0]   lvl_left,
  output logic [7:0]   lvl_right,
  output logic         ovfl
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  function automatic logic [W-1:0] thr(input int k);
    logic [W+16:0] t;
    t = (W+17)'(MAXV);
    for (int i = 0; i < k; i++) t = (t * (W+17)'(RATIO)) >> 16;
    return t[W-1:0];
  endfunction

  logic [2:0]   upd_sync;
  logic         upd_fall;
  logic         bar_q;
  logic [W-1:0] mag;
  logic [7:0]   lvl [2];
  logic [1:0]   ovr_bits;

  assign upd_fall = upd_sync[2] & ~upd_sync[1];
  assign mag = !smp_data[W-1] ? smp_data : (smp_data == MINV) ? MAXV : -smp_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_sync <= 3'b111;
      bar_q    <= bar_mode;
    end else begin
      upd_sync <= {upd_sync[1:0], upd_n};
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic         hit;
    logic [W-1:0] act_mag, out_mag;
    logic         act_ovr, out_ovr;
    logic [1:0]   act_xs, out_xs;
    logic [STEPS:0] below;
    logic [5:0]   att;
    logic         idle;
    logic [7:0]   hires, bar;

    assign hit = smp_valid && (smp_right == 1'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act_mag <= '0; act_ovr <= 1'b0; act_xs <= '0;
        out_mag <= '0; out_ovr <= 1'b0; out_xs <= '0;
      end else if (upd_fall) begin
        out_mag <= act_mag; out_ovr <= act_ovr; out_xs <= act_xs;
        act_mag <= hit ? mag : '0;
        act_ovr <= hit & smp_over;
        act_xs  <= (hit & smp_over) ? smp_excess : 2'd0;
      end else if (hit) begin
        if (mag > act_mag) act_mag <= mag;
        if (smp_over) begin
          act_ovr <= 1'b1;
          if (smp_excess > act_xs) act_xs <= smp_excess;
        end
      end
    end

    for (genvar k = 0; k <= STEPS; k++) begin : g_cmp
      localparam logic [W-1:0] TK = thr(k);
      assign below[k] = out_mag < TK;
    end

    assign att  = 6'($countones(below[STEPS-1:0]));
    assign idle = below[STEPS];
    assign hires = {out_ovr, ~out_ovr & idle, out_ovr ? {4'd0, out_xs} : att};

    always_comb begin
      if (out_ovr)        bar = 8'hFF;
      else if (idle)      bar = 8'h00;
      else if (att <= 3)  bar = 8'h7F;
      else if (att <= 6)  bar = 8'h3F;
      else if (att <= 10) bar = 8'h1F;
      else if (att <= 20) bar = 8'h0F;
      else if (att <= 30) bar = 8'h07;
      else if (att <= 40) bar = 8'h03;
      else                bar = 8'h01;
    end

    assign lvl[c]      = bar_q ? bar : hires;
    assign ovr_bits[c] = out_ovr;
  end

  assign lvl_left  = lvl[0];
  assign lvl_right = lvl[1];
  assign ovfl      = lr_right ? ovr_bits[1] : ovr_bits[0];
endmodule

module plm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] lvl_left,
  input logic [7:0] lvl_right,
  input logic       ovfl,
  input logic       lr_right,
  input logic       upd_fall,
  input logic       bar_q
);
  AST_HOLD_BETWEEN_UPDATES: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(upd_fall) |-> $stable(lvl_left) && $stable(lvl_right)); // R1
  AST_MODE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(bar_q)); // R8
  AST_OVFL_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!bar_q && !lr_right) |-> ovfl == lvl_left[7]); // R7
  AST_OVFL_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (!bar_q && lr_right) |-> ovfl == lvl_right[7]); // R7
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bar_q && lvl_left[6]) |-> !lvl_left[7] && lvl_left[5:0] == 6'd60); // R4
  AST_ATT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bar_q && !lvl_right[7]) |-> lvl_right[5:0] <= 6'd60); // R3
  AST_EXCESS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bar_q && lvl_left[7]) |-> lvl_left[5:0] <= 6'd3 && !lvl_left[6]); // R5
  AST_BAR_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    bar_q |-> ((8'(lvl_left + 8'd1) & lvl_left) == 8'd0) &&
              ((8'(lvl_right + 8'd1) & lvl_right) == 8'd0)); // R6
endmodule

bind peak_level_monitor plm_checker u_chk (.*);

// File: tb/tb_peak_level_monitor.sv
module tb_peak_level_monitor;
  localparam int STEPS = 60;
  localparam longint FS = 524287;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, smp_valid = 1'b0, smp_right = 1'b0, smp_over = 1'b0;
  logic [19:0] smp_data = '0;
  logic [1:0] smp_excess = '0;
  logic upd_n = 1'b1, lr_right = 1'b0, bar_mode = 1'b0;
  logic [7:0] lvl_left, lvl_right;
  logic ovfl;

  peak_level_monitor dut (.*);

  int vectors = 0, miscompares = 0;
  bit cmp_on = 0;
  longint thr [0:STEPS];

  initial begin
    thr[0] = FS;
    for (int k = 1; k <= STEPS; k++) thr[k] = (thr[k-1] * 58409) >> 16;
  end

  function automatic longint mag_of(logic [19:0] d);
    longint v;
    v = longint'($signed(d));
    if (v < 0) v = -v;
    if (v > FS) v = FS;
    return v;
  endfunction

  function automatic int att_of(longint m);
    int n = 0;
    for (int k = 0; k < STEPS; k++) if (m < thr[k]) n++;
    return n;
  endfunction

  function automatic logic [7:0] enc(bit bar, bit ovr, int xs, longint m);
    int a;
    bit idle;
    a = att_of(m);
    idle = m < thr[STEPS];
    if (!bar) return ovr ? {2'b10, 6'(xs)} : {1'b0, idle, 6'(a)};
    if (ovr) return 8'hFF;
    if (idle) return 8'h00;
    if (a <= 3) return 8'h7F;
    if (a <= 6) return 8'h3F;
    if (a <= 10) return 8'h1F;
    if (a <= 20) return 8'h0F;
    if (a <= 30) return 8'h07;
    if (a <= 40) return 8'h03;
    return 8'h01;
  endfunction

  // reference model
  longint am [2], om [2];
  bit ao [2], oo [2];
  int ax [2], ox [2];
  bit mbar;
  bit h0 = 1, h1 = 1, h2 = 1;

  always @(posedge clk) begin : model
    bit fall, hit;
    longint m;
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        am[c] = 0; om[c] = 0; ao[c] = 0; oo[c] = 0; ax[c] = 0; ox[c] = 0;
      end
      mbar = bar_mode;
      h0 = 1; h1 = 1; h2 = 1;
    end else begin
      fall = h2 && !h1;
      m = mag_of(smp_data);
      for (int c = 0; c < 2; c++) begin
        hit = smp_valid && (int'(smp_right) == c);
        if (fall) begin
          om[c] = am[c]; oo[c] = ao[c]; ox[c] = ax[c];
          am[c] = hit ? m : 0;
          ao[c] = hit && smp_over;
          ax[c] = (hit && smp_over) ? int'(smp_excess) : 0;
        end else if (hit) begin
          if (m > am[c]) am[c] = m;
          if (smp_over) begin
            ao[c] = 1;
            if (int'(smp_excess) > ax[c]) ax[c] = int'(smp_excess);
          end
        end
      end
      h2 = h1; h1 = h0; h0 = upd_n;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (cmp_on) begin
      chk(mbar ? "R6 left" : "R4 left", lvl_left, enc(mbar, oo[0], ox[0], om[0]));
      chk(mbar ? "R6 right" : "R4 right", lvl_right, enc(mbar, oo[1], ox[1], om[1]));
      chk("R7 ovfl", {7'd0, ovfl}, {7'd0, lr_right ? oo[1] : oo[0]});
    end
  endtask

  task automatic send(bit right, logic [19:0] d, bit ov = 0, logic [1:0] xs = 0);
    smp_valid = 1; smp_right = right; smp_data = d; smp_over = ov; smp_excess = xs;
    step();
    smp_valid = 0; smp_over = 0; smp_excess = 0;
  endtask

  task automatic pulse();
    upd_n = 0; repeat (4) step();
    upd_n = 1; repeat (4) step();
  endtask

  task automatic do_reset(bit mode);
    cmp_on = 0;
    bar_mode = mode;
    @(negedge clk);
    rst_n = 0;
    repeat (3) step();
    rst_n = 1;
    cmp_on = 1;
    step();
  endtask

  task automatic run_mode(bit mode);
    logic [7:0] old;
    int ks [16] = '{0, 1, 3, 4, 6, 7, 10, 11, 20, 21, 30, 31, 40, 41, 59, 60};
    do_reset(mode);
    // R9 reset state
    chk("R9 left", lvl_left, mode ? 8'h00 : 8'h7C);
    chk("R9 right", lvl_right, mode ? 8'h00 : 8'h7C);
    chk("R9 ovfl", {7'd0, ovfl}, 8'd0);
    // R8: input changes after reset are ignored
    bar_mode = ~mode;
    send(0, 20'h7FFFF);
    pulse();
    chk("R8 mode held", lvl_left, mode ? 8'h7F : 8'h00);
    // R1: update timing, old code for two edges then new
    pulse();
    send(0, 20'h7FFFF);
    old = mode ? 8'h00 : 8'h7C;
    upd_n = 0;
    step(); chk("R1 edge1", lvl_left, old);
    step(); chk("R1 edge2", lvl_left, old);
    step(); chk("R1 edge3", lvl_left, mode ? 8'h7F : 8'h00);
    upd_n = 1; repeat (3) step();
    pulse();
    chk("R1 restart", lvl_left, old);
    // R3 boundaries, R2 negative values, R10 independence
    foreach (ks[i]) begin
      send(0, 20'(thr[ks[i]]));
      send(1, 20'(-(thr[ks[i]] - 1)));
      pulse();
      chk("R3 left at threshold", lvl_left, enc(mode, 0, 0, thr[ks[i]]));
      chk("R3 right below threshold", lvl_right, enc(mode, 0, 0, thr[ks[i]] - 1));
    end
    if (!mode) begin
      send(0, 20'(thr[5]));
      pulse();
      chk("R3 exact step 5", lvl_left, 8'h05);
      send(0, 20'(thr[STEPS] - 1));
      pulse();
      chk("R4 idle", lvl_left, 8'h7C);
    end
    // R2 clamp and peak of several samples
    send(1, 20'h80000);
    send(1, 20'h00010);
    pulse();
    chk("R2 clamp", lvl_right, mode ? 8'h7F : 8'h00);
    send(0, 20'h00400); send(0, 20'hF0000); send(0, 20'h00100);
    pulse();
    chk("R2 peak", lvl_left, enc(mode, 0, 0, 65536));
    chk("R10 right untouched", lvl_right, mode ? 8'h00 : 8'h7C);
    // R5 excess, R7 overflow pin
    send(0, 20'h7FFFF, 1, 2'd2);
    send(0, 20'h7FFFF, 1, 2'd1);
    send(0, 20'h7FFFF, 0, 2'd3);
    pulse();
    chk("R5 excess", lvl_left, mode ? 8'hFF : 8'h82);
    lr_right = 0; step();
    chk("R7 left phase", {7'd0, ovfl}, 8'd1);
    lr_right = 1; step();
    chk("R7 right phase", {7'd0, ovfl}, 8'd0);
    send(1, 20'h7FFFF, 1, 2'd3);
    pulse();
    chk("R7 right flag", {7'd0, ovfl}, 8'd1);
    lr_right = 0; step();
    chk("R7 left cleared", {7'd0, ovfl}, 8'd0);
    // random traffic compared with the model every cycle
    for (int i = 0; i < 3000; i++) begin
      smp_valid = ($urandom % 3) != 0;
      smp_right = 1'($urandom);
      smp_data = 20'($urandom >> ($urandom % 24));
      if ($urandom % 2) smp_data = -smp_data;
      if ($urandom % 50 == 0) smp_data = 20'h80000;
      smp_over = ($urandom % 16) == 0;
      smp_excess = 2'($urandom);
      lr_right = 1'($urandom);
      if ($urandom % 6 == 0) upd_n = ~upd_n;
      step();
    end
    smp_valid = 0; smp_over = 0; upd_n = 1;
    repeat (6) step();
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    run_mode(0);
    run_mode(1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule